// File: doc/BRIEF.md
# Priority Request Arbiter with Hold

This block picks one owner among 32 request lines. Each line has its own small priority byte, made of a level from 0 to 7 and a hold flag. In every cycle the block finds the active line with the highest level. When levels are equal, the line with the larger index wins. The block registers the result as a one-hot grant vector, a binary grant index and a valid flag.

An owner whose hold flag is set keeps the grant even when a stronger request shows up. It gives the grant up only when its own request falls or the `done` input pulses to say its work is complete. An owner whose hold flag is clear is re-arbitrated every cycle, so a higher level takes the grant at once.

Software sets each priority byte through a simple indexed write port. A combinational read of the byte at the same index returns the stored fields.

Slot 0 can be tied on as a permanent background requester. The `SLOT0_ALWAYS` parameter selects this and is set by default. With it set, the lowest slot always has a request pending, so the grant is valid in every cycle after reset.

Top module: `prio_arb`

## Requirements
- R1: At most one bit of `gnt` is set. `gnt_vld` is high exactly when `gnt` is non-zero, and in that case `gnt[gnt_idx]` is set.
- R2: Among active requests, the one with the larger 3-bit level wins. Level 7 is served first and level 0 is served last.
- R3: When several active requests share the top level, the one with the larger index wins. This holds for both index 31 and index 0.
- R4: The priority byte places the hold flag in bit 7 and the level in bits 2..0. Bits 6..3 are discarded on write and read back as zero. After reset, every byte reads 0x00.
- R5: If the owner's hold flag is set, it keeps the grant while its request stays high and `done` is low, even when a higher level is active. If its request drops, or `done` is high in a cycle, the next grant is decided by normal arbitration.
- R6: If the owner's hold flag is clear, a higher-level active request takes the grant at the next clock edge.
- R7: The grant outputs are registered and reflect the requests and priorities present before the edge. A byte written at edge k takes part in arbitration from edge k+1 on.
- R8: With `SLOT0_ALWAYS`=1, slot 0 counts as requesting whatever `req[0]` carries. With no other request, slot 0 is granted.
- R9: During reset and while no line is active, `gnt_vld` is 0 and `gnt` is all zeros. A grant goes only to a line that was active in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 32 | Request lines, one per slot |
| done | input | 1 | Pulse from the current owner meaning its work is finished |
| cfg_we | input | 1 | Write strobe for the priority byte |
| cfg_idx | input | 5 | Slot selected for write and read |
| cfg_wdata | input | 8 | Byte to store: bit 7 hold, bits 2..0 level |
| cfg_rdata | output | 8 | Stored byte of slot `cfg_idx`, with bits 6..3 zero |
| gnt | output | 32 | One-hot grant |
| gnt_idx | output | 5 | Index of the granted slot |
| gnt_vld | output | 1 | A grant is present |

## Verification
Two events can land in the same cycle: a `done` pulse from a holding owner and the arrival of a higher-level request. The bench raises both at the same clock edge and expects the newcomer to own the grant after that one edge. A priority write can also coincide with arbitration. The bench writes a new level while two equal-level lines compete and expects the old winner to stay for exactly one more edge, then hand over to the line that was written.

// File: rtl/prio_arb.sv
module prio_arb #(
  parameter int N            = 32,
  parameter int LVL_W        = 3,
  parameter int IDX_W        = $clog2(N),
  parameter bit SLOT0_ALWAYS = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     req,
  input  logic             done,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [7:0]       cfg_wdata,
  output logic [7:0]       cfg_rdata,
  output logic [N-1:0]     gnt,
  output logic [IDX_W-1:0] gnt_idx,
  output logic             gnt_vld
);
  localparam int HOLD_BIT = 7;
  localparam int RSV_W    = HOLD_BIT - LVL_W;

  logic [LVL_W-1:0] lvl_q [N];
  logic [N-1:0]     hold_q;
  logic [N-1:0]     act;
  logic             best_vld;
  logic [IDX_W-1:0] best_idx;
  logic [LVL_W-1:0] best_lvl;
  logic             keep;
  logic             unused_rsv;

  generate
    if (SLOT0_ALWAYS) begin : g_slot0_on
      assign act = {req[N-1:1], 1'b1};
      logic unused_req0;
      assign unused_req0 = req[0];
    end else begin : g_slot0_req
      assign act = req;
    end
  endgenerate

  assign unused_rsv = ^cfg_wdata[HOLD_BIT-1:LVL_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      for (int i = 0; i < N; i++) lvl_q[i] <= '0;
    end else if (cfg_we) begin
      hold_q[cfg_idx] <= cfg_wdata[HOLD_BIT];
      lvl_q[cfg_idx]  <= cfg_wdata[LVL_W-1:0];
    end
  end

  assign cfg_rdata = {hold_q[cfg_idx], {RSV_W{1'b0}}, lvl_q[cfg_idx]};

  always_comb begin
    best_vld = 1'b0;
    best_idx = '0;
    best_lvl = '0;
    for (int i = 0; i < N; i++) begin
      if (act[i] && (!best_vld || lvl_q[i] >= best_lvl)) begin
        best_vld = 1'b1;
        best_idx = IDX_W'(i);
        best_lvl = lvl_q[i];
      end
    end
  end

  assign keep = gnt_vld && hold_q[gnt_idx] && act[gnt_idx] && !done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_vld <= 1'b0;
      gnt_idx <= '0;
    end else if (!keep) begin
      gnt_vld <= best_vld;
      gnt_idx <= best_idx;
    end
  end

  assign gnt = gnt_vld ? ({{(N-1){1'b0}}, 1'b1} << gnt_idx) : '0;

endmodule

// File: rtl/prio_arb_chk.sv
module prio_arb_chk #(
  parameter int N     = 32,
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N-1:0]     act,
  input logic [N-1:0]     hold_q,
  input logic             done,
  input logic [N-1:0]     gnt,
  input logic [IDX_W-1:0] gnt_idx,
  input logic             gnt_vld,
  input logic [3:0]       rsv
);
  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt)); // R1
  AST_VLD_AGREES: assert property (@(posedge clk) disable iff (!rst_n) gnt_vld == (gnt != '0)); // R1
  AST_IDX_AGREES: assert property (@(posedge clk) disable iff (!rst_n) gnt_vld |-> gnt[gnt_idx]); // R1
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n) rsv == 4'd0); // R4
  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_vld && hold_q[gnt_idx] && act[gnt_idx] && !done) |=> (gnt_vld && gnt_idx == $past(gnt_idx))); // R5
  AST_GNT_WAS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld |-> (($past(act) & gnt) != '0)); // R9
  AST_IDLE_NO_GNT: assert property (@(posedge clk) disable iff (!rst_n) (act == '0) |=> !gnt_vld); // R9
endmodule

bind prio_arb prio_arb_chk #(.N(N), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .act(act), .hold_q(hold_q), .done(done),
  .gnt(gnt), .gnt_idx(gnt_idx), .gnt_vld(gnt_vld), .rsv(cfg_rdata[6:3])
);

// File: tb/sim_prio_arb.sv
`timescale 1ns/1ps
module sim_prio_arb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] req = '0;
  logic        done = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_idx = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata, rd1;
  logic [31:0] gnt, gnt1;
  logic [4:0]  gnt_idx, gidx1;
  logic        gnt_vld, gvld1;
  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  prio_arb u0 (.clk(clk), .rst_n(rst_n), .req(req), .done(done), .cfg_we(cfg_we),
    .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .gnt(gnt), .gnt_idx(gnt_idx), .gnt_vld(gnt_vld));

  prio_arb #(.SLOT0_ALWAYS(1'b0)) u1 (.clk(clk), .rst_n(rst_n), .req(req), .done(done),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .cfg_rdata(rd1),
    .gnt(gnt1), .gnt_idx(gidx1), .gnt_vld(gvld1));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic expect_gnt(input string tag, input int idx);
    chk({tag, " vld"}, {31'd0, gnt_vld}, 32'd1);
    chk({tag, " idx"}, {27'd0, gnt_idx}, idx);
    chk({tag, " vec"}, gnt, 32'd1 << idx);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int idx, input logic [7:0] d);
    cfg_idx = 5'(idx); cfg_wdata = d; cfg_we = 1'b1;
    step(1);
    cfg_we = 1'b0;
  endtask

  task automatic t_reset;
    chk("R9 reset vld", {31'd0, gnt_vld}, 32'd0);
    chk("R9 reset gnt", gnt, 32'd0);
    cfg_idx = 5'd5; #1;
    chk("R4 reset byte", {24'd0, cfg_rdata}, 32'd0);
    rst_n = 1'b1;
    step(1);
    expect_gnt("R8 slot0 alone", 0);
    chk("R9 idle u1 vld", {31'd0, gvld1}, 32'd0);
    chk("R9 idle u1 gnt", gnt1, 32'd0);
    req = 32'd1; step(1);
    chk("R8 u1 req0 real", {27'd0, gidx1}, 32'd0);
    chk("R8 u1 req0 vld", {31'd0, gvld1}, 32'd1);
    req = '0; step(1);
    expect_gnt("R8 req0 low still granted", 0);
  endtask

  task automatic t_readback;
    wr(9, 8'hFF);
    cfg_idx = 5'd9; #1;
    chk("R4 readback", {24'd0, cfg_rdata}, 32'h87);
    wr(9, 8'h7A);
    cfg_idx = 5'd9; #1;
    chk("R4 readback2", {24'd0, cfg_rdata}, 32'h02);
  endtask

  task automatic t_level;
    wr(3, 8'h05); wr(10, 8'h02);
    req = (32'd1 << 10); step(1);
    expect_gnt("R6 low owner", 10);
    req = (32'd1 << 10) | (32'd1 << 3); step(1);
    expect_gnt("R2 R6 preempt", 3);
    req = '0; step(1);
  endtask

  task automatic t_tie;
    wr(7, 8'h04); wr(20, 8'h04);
    req = (32'd1 << 7) | (32'd1 << 20); step(1);
    expect_gnt("R3 tie", 20);
    wr(7, 8'h06);
    expect_gnt("R7 write not yet seen", 20);
    step(1);
    expect_gnt("R7 write seen", 7);
    req = '0; step(1);
  endtask

  task automatic t_hold;
    wr(12, 8'h81); wr(25, 8'h06);
    req = (32'd1 << 12); step(1);
    expect_gnt("R5 hold owner", 12);
    req = (32'd1 << 12) | (32'd1 << 25); step(3);
    expect_gnt("R5 hold blocks", 12);
    req = (32'd1 << 25); step(1);
    expect_gnt("R5 release on drop", 25);
    req = (32'd1 << 12); step(1);
    expect_gnt("R5 hold again", 12);
    req = (32'd1 << 12) | (32'd1 << 25); done = 1'b1; step(1);
    done = 1'b0;
    expect_gnt("R5 done and newcomer same edge", 25);
    req = '0; step(1);
  endtask

  task automatic t_edges;
    wr(0, 8'h07); wr(31, 8'h07);
    req = (32'd1 << 31); step(1);
    expect_gnt("R3 idx31 over idx0", 31);
    req = '0; step(1);
    expect_gnt("R3 idx0 at lvl7", 0);
  endtask

  initial begin
    step(2);
    t_reset;
    t_readback;
    t_level;
    t_tie;
    t_hold;
    t_edges;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule